// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one channel of a timer running in output-compare mode. It watches a counter value taken from one of two counter buses: an internal one or an external one. When that counter first equals the programmed compare value, the channel updates its output flip-flop and raises a sticky status flag. On a match the output either toggles or loads a polarity level, chosen by an edge-select control.

The compare value has two stages. Software writes land in a staging register. A read returns the active register, and only the active register is compared. The staging value moves into the active register on each clock while the update-enable input is high.

A software force pulse produces the same output action as a real match but leaves the flag alone. In GPIO mode the output simply follows a software level, and matches and force pulses are ignored. When the channel switches from GPIO into output-compare mode, the output is preset to the inverse of the polarity bit.

Top module: `ocmp_channel`

## Requirements
- R1: A write (`wr_en`=1) stores `wr_data` in the staging register only. While `upd_en`=0, `rd_data` does not change and matches use the old active value.
- R2: While `upd_en`=1, the active register takes the staging value at the next clock edge, and `rd_data` shows the active register from then on.
- R3: `bus_sel`=0 compares the active value against `cnt_int` and `bus_sel`=1 compares it against `cnt_ext`. A match on the bus that is not selected has no effect.
- R4: With `edge_toggle`=1, each match inverts `out_pin` at the clock edge that ends the first cycle in which the selected counter equals the active value.
- R5: With `edge_toggle`=0, a match loads `out_pin` with `pol` at that same edge.
- R6: A match sets `flag` at the same edge that updates `out_pin`. The flag stays set until `flag_clr`=1 clears it. If a match and a clear arrive in the same cycle, the flag is set.
- R7: A `force_pulse` cycle in output-compare mode applies the same output action as a match (toggle or load `pol`), and `flag` is not changed.
- R8: A match fires only on the first cycle of equality. Holding the counter at the compare value does not repeat the action.
- R9: With `mode_oc`=0 (GPIO), `out_pin` takes `gpio_level` one edge later. Matches and `force_pulse` have no effect, and `flag` is not set.
- R10: In the first cycle with `mode_oc`=1 after a cycle with `mode_oc`=0, `out_pin` is loaded with the inverse of `pol`. This preset takes priority over any match or force in that cycle.
- R11: After reset, `out_pin`=0, `flag`=0 and `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_oc | input | 1 | 1 = output compare, 0 = GPIO |
| gpio_level | input | 1 | Output level used in GPIO mode |
| bus_sel | input | 1 | Counter bus select: 0 internal, 1 external |
| edge_toggle | input | 1 | Match action: 1 toggle, 0 load polarity |
| pol | input | 1 | Polarity level |
| upd_en | input | 1 | Enables the staging-to-active transfer |
| cnt_int | input | CNT_W | Internal counter bus |
| cnt_ext | input | CNT_W | External counter bus |
| wr_en | input | 1 | Write strobe for the compare value |
| wr_data | input | CNT_W | Compare value to stage |
| rd_data | output | CNT_W | Active compare value |
| force_pulse | input | 1 | One-cycle software force-match |
| flag_clr | input | 1 | Write-one clear of the flag |
| flag | output | 1 | Match status flag |
| out_pin | output | 1 | Output flip-flop |

## Verification
The counter value presented in a given cycle is judged against the active register through a single edge detector. The resulting `out_pin` and `flag` values therefore appear just after the next rising edge. A staged write reaches `rd_data` one edge after `upd_en` is seen high, and the GPIO level and the mode-entry preset also land one edge later. The bench applies each stimulus on a falling edge, waits for one rising edge, and samples 1 ns after it. Each table row therefore checks exactly the edge that row's inputs caused.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

    typedef enum logic {
        BUS_INTERNAL = 1'b0,
        BUS_EXTERNAL = 1'b1
    } bus_sel_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_LOAD   = 2'd1,
        ACT_TOGGLE = 2'd2,
        ACT_PRESET = 2'd3
    } out_action_e;

endpackage

// File: rtl/ocmp_buffer.sv
module ocmp_buffer #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             upd_en,
    output logic [CNT_W-1:0] active_o
);

    typedef struct packed {
        logic [CNT_W-1:0] staging;
        logic [CNT_W-1:0] active;
    } buf_state_t;

    buf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.staging = wr_data;
        end
        if (upd_en) begin
            st_d.active = st_q.staging;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;

endmodule

// File: rtl/ocmp_match.sv
module ocmp_match
    import ocmp_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_int,
    input  logic [CNT_W-1:0] cnt_ext,
    input  logic             bus_sel,
    input  logic [CNT_W-1:0] active,
    output logic             hit_o
);

    typedef struct packed {
        logic eq_prev;
    } match_state_t;

    match_state_t     st_d, st_q;
    logic [CNT_W-1:0] cnt_sel;
    logic             eq_now;

    always_comb begin
        unique case (bus_sel_e'(bus_sel))
            BUS_EXTERNAL: cnt_sel = cnt_ext;
            default:      cnt_sel = cnt_int;
        endcase
        eq_now     = (cnt_sel == active);
        hit_o      = eq_now && !st_q.eq_prev;
        st_d       = st_q;
        st_d.eq_prev = eq_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ocmp_outflag.sv
module ocmp_outflag
    import ocmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_oc,
    input  logic gpio_level,
    input  logic edge_toggle,
    input  logic pol,
    input  logic hit,
    input  logic force_pulse,
    input  logic flag_clr,
    output logic out_o,
    output logic flag_o
);

    typedef struct packed {
        logic out;
        logic flag;
        logic mode_prev;
    } of_state_t;

    of_state_t   st_d, st_q;
    out_action_e act;
    logic        entering;
    logic        real_hit;

    always_comb begin
        entering = mode_oc && !st_q.mode_prev;
        real_hit = mode_oc && !entering && hit;

        if (!mode_oc) begin
            act = ACT_NONE;
        end else if (entering) begin
            act = ACT_PRESET;
        end else if (real_hit || force_pulse) begin
            act = edge_toggle ? ACT_TOGGLE : ACT_LOAD;
        end else begin
            act = ACT_NONE;
        end

        st_d           = st_q;
        st_d.mode_prev = mode_oc;

        if (!mode_oc) begin
            st_d.out = gpio_level;
        end else begin
            unique case (act)
                ACT_PRESET: st_d.out = !pol;
                ACT_TOGGLE: st_d.out = !st_q.out;
                ACT_LOAD:   st_d.out = pol;
                default:    st_d.out = st_q.out;
            endcase
        end

        if (real_hit) begin
            st_d.flag = 1'b1;
        end else if (flag_clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_o  = st_q.out;
    assign flag_o = st_q.flag;

endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_oc,
    input  logic             gpio_level,
    input  logic             bus_sel,
    input  logic             edge_toggle,
    input  logic             pol,
    input  logic             upd_en,
    input  logic [CNT_W-1:0] cnt_int,
    input  logic [CNT_W-1:0] cnt_ext,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] rd_data,
    input  logic             force_pulse,
    input  logic             flag_clr,
    output logic             flag,
    output logic             out_pin
);

    logic [CNT_W-1:0] active;
    logic             hit;

    ocmp_buffer #(.CNT_W(CNT_W)) i_buffer (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .upd_en   (upd_en),
        .active_o (active)
    );

    ocmp_match #(.CNT_W(CNT_W)) i_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_int (cnt_int),
        .cnt_ext (cnt_ext),
        .bus_sel (bus_sel),
        .active  (active),
        .hit_o   (hit)
    );

    ocmp_outflag i_outflag (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_oc     (mode_oc),
        .gpio_level  (gpio_level),
        .edge_toggle (edge_toggle),
        .pol         (pol),
        .hit         (hit),
        .force_pulse (force_pulse),
        .flag_clr    (flag_clr),
        .out_o       (out_pin),
        .flag_o      (flag)
    );

    assign rd_data = active;

endmodule

// File: rtl/ocmp_channel_chk.sv
module ocmp_channel_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_oc,
    input logic             gpio_level,
    input logic             bus_sel,
    input logic             pol,
    input logic             upd_en,
    input logic [CNT_W-1:0] cnt_int,
    input logic [CNT_W-1:0] cnt_ext,
    input logic [CNT_W-1:0] rd_data,
    input logic             force_pulse,
    input logic             flag_clr,
    input logic             flag,
    input logic             out_pin
);

    logic [CNT_W-1:0] seen_cnt;
    assign seen_cnt = bus_sel ? cnt_ext : cnt_int;

    // R1
    hold_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(rd_data));

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !flag_clr |=> flag);

    // R9
    gpio_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_oc |=> out_pin == $past(gpio_level));

    // R9
    gpio_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_oc && !flag |=> !flag);

    // R10
    entry_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_oc ##1 mode_oc |=> out_pin == !$past(pol));

    // R7
    force_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_oc && force_pulse && !flag && (seen_cnt != rd_data) |=> !flag);

endmodule

bind ocmp_channel ocmp_channel_chk #(.CNT_W(CNT_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_oc     (mode_oc),
    .gpio_level  (gpio_level),
    .bus_sel     (bus_sel),
    .pol         (pol),
    .upd_en      (upd_en),
    .cnt_int     (cnt_int),
    .cnt_ext     (cnt_ext),
    .rd_data     (rd_data),
    .force_pulse (force_pulse),
    .flag_clr    (flag_clr),
    .flag        (flag),
    .out_pin     (out_pin)
);

// File: tb/test_ocmp_channel.sv
module test_ocmp_channel;

    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_oc = 1'b0, gpio_level = 1'b0, bus_sel = 1'b0;
    logic         edge_toggle = 1'b0, pol = 1'b0, upd_en = 1'b0;
    logic [W-1:0] cnt_int = '0, cnt_ext = '0, wr_data = '0;
    logic         wr_en = 1'b0, force_pulse = 1'b0, flag_clr = 1'b0;
    logic [W-1:0] rd_data;
    logic         flag, out_pin;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ocmp_channel #(.CNT_W(W)) i_ocmp_channel (
        .clk(clk), .rst_n(rst_n), .mode_oc(mode_oc), .gpio_level(gpio_level),
        .bus_sel(bus_sel), .edge_toggle(edge_toggle), .pol(pol), .upd_en(upd_en),
        .cnt_int(cnt_int), .cnt_ext(cnt_ext), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .force_pulse(force_pulse), .flag_clr(flag_clr),
        .flag(flag), .out_pin(out_pin)
    );

    typedef struct packed {
        logic [W-1:0] ci;
        logic [W-1:0] ce;
        logic         bsel;
        logic         edg;
        logic         pl;
        logic         frc;
        logic         clr;
        logic         eout;
        logic         eflag;
        logic [7:0]   req;
    } vec_t;

    // Active value 0x1000, out=0, flag=0 on entry to the table.
    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{24'h000FFF, 24'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd5},  // R5 before match
        '{24'h001000, 24'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'd5},  // R5 R6 load pol, flag
        '{24'h001000, 24'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'd8},  // R8 hold
        '{24'h001001, 24'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'd6},  // R6 clear
        '{24'h001002, 24'h001000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd3}, // R3 other bus
        '{24'h0, 24'h000FFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd3},  // R3 switch bus
        '{24'h0, 24'h001000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd4},  // R4 toggle
        '{24'h0, 24'h001000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd8},  // R8 no repeat
        '{24'h0, 24'h001001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd6},  // R6 sticky
        '{24'h0, 24'h001000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd4},  // R4 second toggle
        '{24'h0, 24'h001002, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd6},  // R6 clear
        '{24'h0, 24'h001003, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd7},  // R7 force toggle
        '{24'h0, 24'h001003, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'd7},  // R7 force load
        '{24'h0, 24'h001000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'd6}   // R6 set beats clear
    };

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R11 reset state
        check("R11 out", {23'b0, out_pin}, '0);
        check("R11 flag", {23'b0, flag}, '0);
        check("R11 rd", rd_data, '0);
        rst_n = 1'b1;

        // R9 GPIO follows level, force ignored
        @(negedge clk);
        gpio_level  = 1'b1;
        force_pulse = 1'b1;
        step();
        check("R9 gpio level", {23'b0, out_pin}, 24'd1);
        @(negedge clk);
        force_pulse = 1'b0;

        // R1 write stages only
        wr_en = 1'b1; wr_data = 24'h001000;
        step();
        @(negedge clk);
        wr_en = 1'b0;
        step();
        check("R1 rd unchanged", rd_data, '0);

        // R2 transfer when enabled
        @(negedge clk);
        upd_en = 1'b1;
        step();
        check("R2 rd active", rd_data, 24'h001000);

        // R10 entry preset: pol=1 -> out 0
        @(negedge clk);
        pol = 1'b1; cnt_int = 24'h000100; mode_oc = 1'b1;
        step();
        check("R10 preset", {23'b0, out_pin}, '0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cnt_int = VEC[i].ci; cnt_ext = VEC[i].ce; bus_sel = VEC[i].bsel;
            edge_toggle = VEC[i].edg; pol = VEC[i].pl;
            force_pulse = VEC[i].frc; flag_clr = VEC[i].clr;
            step();
            check($sformatf("R%0d out vec%0d", VEC[i].req, i), {23'b0, out_pin}, {23'b0, VEC[i].eout});
            check($sformatf("R%0d flag vec%0d", VEC[i].req, i), {23'b0, flag}, {23'b0, VEC[i].eflag});
        end

        // R1 staged value not compared while updates are off
        @(negedge clk);
        force_pulse = 1'b0; flag_clr = 1'b1; upd_en = 1'b0;
        wr_en = 1'b1; wr_data = 24'h002000; cnt_ext = 24'h001FFF;
        step();
        @(negedge clk);
        wr_en = 1'b0; flag_clr = 1'b0; cnt_ext = 24'h002000;
        step();
        check("R1 no match on staged", {23'b0, flag}, '0);
        check("R1 rd old", rd_data, 24'h001000);

        // R2 enable: active becomes staged value
        @(negedge clk);
        upd_en = 1'b1; cnt_ext = 24'h0;
        step();
        check("R2 rd new", rd_data, 24'h002000);

        // R9 GPIO: match has no flag effect
        @(negedge clk);
        mode_oc = 1'b0; gpio_level = 1'b0;
        step();
        check("R9 gpio out", {23'b0, out_pin}, '0);
        @(negedge clk);
        cnt_ext = 24'h002000; gpio_level = 1'b1;
        step();
        check("R9 no flag", {23'b0, flag}, '0);
        check("R9 follows", {23'b0, out_pin}, 24'd1);

        // R10 entry with pol=0 -> out 1
        @(negedge clk);
        gpio_level = 1'b0; pol = 1'b0; cnt_ext = 24'h0; mode_oc = 1'b1;
        step();
        check("R10 preset pol0", {23'b0, out_pin}, 24'd1);

        finish_run();
    end

endmodule